// File: doc/BRIEF.md
# NAND Flash Identification and Geometry Decoder

This block identifies a raw NAND flash device and works out its geometry. It runs when `start` is pulsed, which can happen once after power-up or whenever software wants a fresh probe. The block drives a simple one-operation-at-a-time bus toward a flash controller. Each operation is a command byte, an address byte or a data read, and each completes when the controller acknowledges it. The block first sends a reset command and waits for the device's ready/busy line. It then sends a read-ID command with a single zero address byte and reads back the manufacturer code and the device code.

The device code is looked up in a small internal table of geometry records. If the matching record leaves the page size or the erase-block size open, the block reads three further ID bytes. It then decodes the missing fields from the second of those bytes. From the record and the decoded fields it publishes the following:

- page size in bytes
- erase-block size in KiB
- data-bus width flag
- number of address cycles
- number of erase blocks

It also reports a valid flag, or one of two error flags. The raw ID bytes always remain visible on the outputs after a probe.

Top module: `nand_id_probe`

Internal device table. Rows are searched from lowest index to highest. A blank page or erase value means the field is decoded from the ID byte.

| Idx | Mfr | Dev | Page (B) | Chip (MiB) | Erase (KiB) | 16-bit |
|-----|-----|-----|----------|------------|-------------|--------|
| 0 | 0xEC | 0xD5 | 8192 | 2048 | 1024 | no |
| 1 | any | 0x6E | 256 | 1 | 4 | no |
| 2 | any | 0x73 | 512 | 16 | 16 | no |
| 3 | any | 0x53 | 512 | 16 | 16 | yes |
| 4 | any | 0x75 | 512 | 32 | 16 | no |
| 5 | any | 0x76 | 512 | 64 | 16 | no |
| 6 | any | 0x79 | 512 | 128 | 16 | no |
| 7 | any | 0xF1 | – | 128 | – | no |
| 8 | any | 0xC1 | – | 128 | – | yes |
| 9 | any | 0xDA | – | 256 | – | no |
| 10 | any | 0xD3 | – | 1024 | – | no |
| 11 | any | 0xD5 | – | 2048 | – | no |
| 12 | any | 0x48 | – | 2048 | – | no |

## Requirements
- R1: The bus encodes each operation in `bus_kind`: 0 is a command, 1 is an address and 2 is a read. `bus_req` stays high with a stable kind and byte until `bus_ack`. A probe issues, in order: command 0xFF, command 0x90, address 0x00, then a read for the manufacturer byte and a read for the device byte.
- R2: After the 0xFF command is acknowledged, command 0x90 is not requested until `rb_ready` is high.
- R3: Only bits [7:0] of `bus_rdata` are used from every read; bits [15:8] have no effect on any output.
- R4: A table row matches when its device code equals the device byte and its manufacturer field is "any" or equals the manufacturer byte. The lowest-index matching row is used.
- R5: If the matched row leaves page or erase size open, exactly three more reads follow the device byte. Otherwise no further read is made.
- R6: If the page size is open, `page_bytes` = 1 << (10 + (E & 3)), where E is the second of the three extra bytes.
- R7: If the erase size is open, `erase_kib` = 64 << ((E >> 4) & 3).
- R8: `addr_cycles` depends on page size and chip capacity. With a page of at most 512 B: 3 cycles up to 32 MiB, 4 cycles up to 8 GiB, otherwise 5. With a larger page: 4 cycles up to 128 MiB, 5 cycles up to 32 GiB, otherwise 6.
- R9: `block_count` = chip MiB × 1024 / `erase_kib`.
- R10: If no row matches, `err_unknown` is set, `geom_valid` stays low, the geometry outputs stay 0 and `id_mfr`/`id_dev` show the bytes that were read.
- R11: A matched row with a 256-byte page sets `err_unsupported`, with `geom_valid` low and no extra reads.
- R12: Three timing rules hold around `start`:
  - `start` is ignored while `busy` is high.
  - `start` sampled while idle launches a probe and clears all result flags and fields on that edge.
  - `done` is a one-cycle pulse; results appear in the same cycle and `busy` falls in that cycle.
- R13: `wide16` reports the 16-bit flag of the matched row.
- R14: After reset the block is idle: `busy`, `done`, `bus_req`, `geom_valid` and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a probe |
| rb_ready | input | 1 | Device ready (high) / busy (low) |
| bus_req | output | 1 | Operation pending on the bus |
| bus_kind | output | 2 | 0 command, 1 address, 2 read |
| bus_wdata | output | 8 | Command or address byte |
| bus_ack | input | 1 | Operation complete this cycle |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| geom_valid | output | 1 | Geometry outputs are valid |
| err_unknown | output | 1 | Device code not in table |
| err_unsupported | output | 1 | 256-byte page device |
| id_mfr | output | 8 | Manufacturer byte read |
| id_dev | output | 8 | Device byte read |
| page_bytes | output | 14 | Page size in bytes |
| erase_kib | output | 11 | Erase-block size in KiB |
| wide16 | output | 1 | Device has a 16-bit data bus |
| addr_cycles | output | 3 | Address cycles per page address |
| block_count | output | 22 | Number of erase blocks |

## Verification
The completion of one probe and the launch of the next can fall in the same cycle. This happens when `start` is held high through the end of a probe. The bench provokes it by holding `start` across completion. It then judges that the results are fully present in the `done` cycle, and that on the very next cycle the flags are cleared and a fresh 0xFF command is already requested. A second overlap is a `start` pulse that arrives while reads are being acknowledged. The bench expects it to have no effect, which shows as exactly one reset command in that probe.

// File: rtl/nidp_pkg.sv
// Shared types, widths, opcodes and the device geometry table.
// Sizes in the table are held as base-2 logarithms, so every size and
// count downstream reduces to a shift.
package nidp_pkg;
    localparam int BYTE_W    = 8;
    localparam int RDATA_W   = 16;
    localparam int N_ENTRIES = 13;
    localparam int LG_W      = 5;
    localparam int PAGE_W    = 14;
    localparam int ERASE_W   = 11;
    localparam int BLK_W     = 22;
    localparam int CYC_W     = 3;
    localparam int KIND_W    = 2;

    localparam logic [BYTE_W-1:0] OP_RESET   = 8'hFF;
    localparam logic [BYTE_W-1:0] OP_READ_ID = 8'h90;
    localparam logic [BYTE_W-1:0] ID_ADDR    = 8'h00;

    localparam logic [KIND_W-1:0] KIND_CMD  = 2'd0;
    localparam logic [KIND_W-1:0] KIND_ADDR = 2'd1;
    localparam logic [KIND_W-1:0] KIND_READ = 2'd2;

    // log2 thresholds: page in bytes, chip in MiB
    localparam logic [LG_W-1:0] LG_PAGE_REJECT = 5'd8;   // 256 B
    localparam logic [LG_W-1:0] LG_SMALL_MAX   = 5'd9;   // 512 B
    localparam logic [LG_W-1:0] LG_EXT_PAGE    = 5'd10;  // 1 KiB base
    localparam logic [LG_W-1:0] LG_EXT_ERASE   = 5'd6;   // 64 KiB base
    localparam logic [LG_W-1:0] LG_SP_3CYC     = 5'd5;   // 32 MiB
    localparam logic [LG_W-1:0] LG_SP_4CYC     = 5'd13;  // 8 GiB
    localparam logic [LG_W-1:0] LG_LP_4CYC     = 5'd7;   // 128 MiB
    localparam logic [LG_W-1:0] LG_LP_5CYC     = 5'd15;  // 32 GiB

    typedef struct packed {
        logic [BYTE_W-1:0] mfr;      // 0 = any manufacturer
        logic [BYTE_W-1:0] dev;
        logic [LG_W-1:0]   page_lg;  // 0 = decode from ID byte
        logic [LG_W-1:0]   chip_lg;  // MiB
        logic [LG_W-1:0]   erase_lg; // KiB, 0 = decode from ID byte
        logic              wide;
    } geo_entry_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RST_CMD, ST_RB_WAIT, ST_RID_CMD, ST_RID_ADDR,
        ST_RD_MFR, ST_RD_DEV, ST_MATCH, ST_RD_X3, ST_RD_X4, ST_RD_X5, ST_FIN
    } probe_state_e;

    function automatic geo_entry_t mk(input logic [7:0] m, input logic [7:0] d,
                                      input int pg, input int ch, input int er,
                                      input logic w);
        geo_entry_t e;
        e.mfr = m; e.dev = d;
        e.page_lg = LG_W'(pg); e.chip_lg = LG_W'(ch); e.erase_lg = LG_W'(er);
        e.wide = w;
        return e;
    endfunction

    // Table rows in search order (lower index wins).
    function automatic geo_entry_t entry_at(input int idx);
        case (idx)
            0:  return mk(8'hEC, 8'hD5, 13, 11, 10, 1'b0);
            1:  return mk(8'h00, 8'h6E,  8,  0,  2, 1'b0);
            2:  return mk(8'h00, 8'h73,  9,  4,  4, 1'b0);
            3:  return mk(8'h00, 8'h53,  9,  4,  4, 1'b1);
            4:  return mk(8'h00, 8'h75,  9,  5,  4, 1'b0);
            5:  return mk(8'h00, 8'h76,  9,  6,  4, 1'b0);
            6:  return mk(8'h00, 8'h79,  9,  7,  4, 1'b0);
            7:  return mk(8'h00, 8'hF1,  0,  7,  0, 1'b0);
            8:  return mk(8'h00, 8'hC1,  0,  7,  0, 1'b1);
            9:  return mk(8'h00, 8'hDA,  0,  8,  0, 1'b0);
            10: return mk(8'h00, 8'hD3,  0, 10,  0, 1'b0);
            11: return mk(8'h00, 8'hD5,  0, 11,  0, 1'b0);
            12: return mk(8'h00, 8'h48,  0, 11,  0, 1'b0);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/nidp_seq.sv
// Probe sequencer: walks reset, ready wait, read-ID, address and the ID
// reads over a request/acknowledge bus, and captures the ID bytes.
// Assumes bus_rdata is valid in the cycle bus_ack is high.
module nidp_seq
    import nidp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               rb_ready,
    input  logic               bus_ack,
    input  logic [RDATA_W-1:0] bus_rdata,
    input  logic               hit,
    input  logic               needs_ext,
    output logic               bus_req,
    output logic [KIND_W-1:0]  bus_kind,
    output logic [BYTE_W-1:0]  bus_wdata,
    output logic               busy,
    output logic               launch,
    output logic               fin,
    output logic [BYTE_W-1:0]  mfr_q,
    output logic [BYTE_W-1:0]  dev_q,
    output logic [BYTE_W-1:0]  ext4_q
);
    probe_state_e state, nxt;
    logic [BYTE_W-1:0] rbyte;
    wire unused_rdata_hi = ^bus_rdata[RDATA_W-1:BYTE_W];

    assign rbyte  = bus_rdata[BYTE_W-1:0];
    assign busy   = (state != ST_IDLE);
    assign launch = (state == ST_IDLE) && start;
    assign fin    = (state == ST_FIN);

    // Next-state selection for the probe walk.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:     if (start)    nxt = ST_RST_CMD;
            ST_RST_CMD:  if (bus_ack)  nxt = ST_RB_WAIT;
            ST_RB_WAIT:  if (rb_ready) nxt = ST_RID_CMD;
            ST_RID_CMD:  if (bus_ack)  nxt = ST_RID_ADDR;
            ST_RID_ADDR: if (bus_ack)  nxt = ST_RD_MFR;
            ST_RD_MFR:   if (bus_ack)  nxt = ST_RD_DEV;
            ST_RD_DEV:   if (bus_ack)  nxt = ST_MATCH;
            ST_MATCH:    nxt = (hit && needs_ext) ? ST_RD_X3 : ST_FIN;
            ST_RD_X3:    if (bus_ack)  nxt = ST_RD_X4;
            ST_RD_X4:    if (bus_ack)  nxt = ST_RD_X5;
            ST_RD_X5:    if (bus_ack)  nxt = ST_FIN;
            ST_FIN:      nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Bus request decode from the current state.
    always_comb begin
        bus_req   = 1'b0;
        bus_kind  = KIND_CMD;
        bus_wdata = '0;
        case (state)
            ST_RST_CMD:  begin bus_req = 1'b1; bus_wdata = OP_RESET;   end
            ST_RID_CMD:  begin bus_req = 1'b1; bus_wdata = OP_READ_ID; end
            ST_RID_ADDR: begin bus_req = 1'b1; bus_kind = KIND_ADDR; bus_wdata = ID_ADDR; end
            ST_RD_MFR, ST_RD_DEV, ST_RD_X3, ST_RD_X4, ST_RD_X5:
                         begin bus_req = 1'b1; bus_kind = KIND_READ; end
            default: ;
        endcase
    end

    // Capture of the ID bytes that the decoder needs.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            mfr_q  <= '0;
            dev_q  <= '0;
            ext4_q <= '0;
        end else if (bus_ack) begin
            if (state == ST_RD_MFR) mfr_q  <= rbyte;
            if (state == ST_RD_DEV) dev_q  <= rbyte;
            if (state == ST_RD_X4)  ext4_q <= rbyte;
        end
    end
endmodule

// File: rtl/nidp_lookup.sv
// Table matcher: compares the ID bytes against every row in parallel and
// picks the lowest-index hit. A zero manufacturer field matches any code.
module nidp_lookup
    import nidp_pkg::*;
(
    input  logic [BYTE_W-1:0] mfr,
    input  logic [BYTE_W-1:0] dev,
    output logic              hit,
    output geo_entry_t        sel
);
    geo_entry_t           row     [N_ENTRIES];
    logic [N_ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_row
        assign row[g]     = entry_at(g);
        assign hit_vec[g] = (row[g].dev == dev) &&
                            ((row[g].mfr == '0) || (row[g].mfr == mfr));
    end

    assign hit = |hit_vec;

    // Priority select: the last assignment in the loop is the lowest index.
    always_comb begin
        sel = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel = row[i];
        end
    end
endmodule

// File: rtl/nidp_geom.sv
// Geometry decoder: fills open page/erase sizes from the extended ID byte,
// then derives the address-cycle count and the erase-block count.
// Assumes erase_lg <= chip_lg + 10 (true for every table row).
module nidp_geom
    import nidp_pkg::*;
(
    input  geo_entry_t         ent,
    input  logic [BYTE_W-1:0]  ext4,
    output logic               needs_ext,
    output logic               page_reject,
    output logic [PAGE_W-1:0]  page_bytes,
    output logic [ERASE_W-1:0] erase_kib,
    output logic [CYC_W-1:0]   addr_cycles,
    output logic [BLK_W-1:0]   block_count
);
    logic [LG_W-1:0] page_lg_e, erase_lg_e;
    logic [LG_W:0]   blk_sh;
    wire unused_fields = ^{ent.mfr, ent.dev, ent.wide, ext4[7:6], ext4[3:2]};

    assign needs_ext   = (ent.page_lg == '0) || (ent.erase_lg == '0);
    assign page_reject = (ent.page_lg == LG_PAGE_REJECT);

    // Effective log2 sizes, from the row or from the extended ID byte.
    always_comb begin
        page_lg_e  = (ent.page_lg != '0) ? ent.page_lg
                                         : LG_EXT_PAGE + LG_W'(ext4[1:0]);
        erase_lg_e = (ent.erase_lg != '0) ? ent.erase_lg
                                          : LG_EXT_ERASE + LG_W'(ext4[5:4]);
    end

    assign page_bytes  = PAGE_W'(1) << page_lg_e;
    assign erase_kib   = ERASE_W'(1) << erase_lg_e;
    // chip MiB * 1024 / erase KiB, all powers of two.
    assign blk_sh      = {1'b0, ent.chip_lg} + (LG_W+1)'(10) - {1'b0, erase_lg_e};
    assign block_count = BLK_W'(1) << blk_sh;

    // Address-cycle count from page class and chip capacity.
    always_comb begin
        if (page_lg_e <= LG_SMALL_MAX) begin
            if (ent.chip_lg <= LG_SP_3CYC)      addr_cycles = CYC_W'(3);
            else if (ent.chip_lg <= LG_SP_4CYC) addr_cycles = CYC_W'(4);
            else                                addr_cycles = CYC_W'(5);
        end else begin
            if (ent.chip_lg <= LG_LP_4CYC)      addr_cycles = CYC_W'(4);
            else if (ent.chip_lg <= LG_LP_5CYC) addr_cycles = CYC_W'(5);
            else                                addr_cycles = CYC_W'(6);
        end
    end
endmodule

// File: rtl/nand_id_probe.sv
// Top level: sequencer, table matcher and geometry decoder, plus the
// result registers that are cleared at launch and loaded at completion.
// Assumes a single flash on the bus and a controller that acknowledges
// each requested operation exactly once.
module nand_id_probe
    import nidp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               rb_ready,
    output logic               bus_req,
    output logic [KIND_W-1:0]  bus_kind,
    output logic [BYTE_W-1:0]  bus_wdata,
    input  logic               bus_ack,
    input  logic [RDATA_W-1:0] bus_rdata,
    output logic               busy,
    output logic               done,
    output logic               geom_valid,
    output logic               err_unknown,
    output logic               err_unsupported,
    output logic [BYTE_W-1:0]  id_mfr,
    output logic [BYTE_W-1:0]  id_dev,
    output logic [PAGE_W-1:0]  page_bytes,
    output logic [ERASE_W-1:0] erase_kib,
    output logic               wide16,
    output logic [CYC_W-1:0]   addr_cycles,
    output logic [BLK_W-1:0]   block_count
);
    logic              launch, fin, hit, needs_ext, page_reject;
    logic [BYTE_W-1:0] mfr_q, dev_q, ext4_q;
    geo_entry_t        ent;
    logic [PAGE_W-1:0]  g_page;
    logic [ERASE_W-1:0] g_erase;
    logic [CYC_W-1:0]   g_cyc;
    logic [BLK_W-1:0]   g_blk;

    nidp_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rb_ready(rb_ready),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .hit(hit), .needs_ext(needs_ext),
        .bus_req(bus_req), .bus_kind(bus_kind), .bus_wdata(bus_wdata),
        .busy(busy), .launch(launch), .fin(fin),
        .mfr_q(mfr_q), .dev_q(dev_q), .ext4_q(ext4_q)
    );

    nidp_lookup u_lookup (
        .mfr(mfr_q), .dev(dev_q), .hit(hit), .sel(ent)
    );

    nidp_geom u_geom (
        .ent(ent), .ext4(ext4_q), .needs_ext(needs_ext), .page_reject(page_reject),
        .page_bytes(g_page), .erase_kib(g_erase), .addr_cycles(g_cyc),
        .block_count(g_blk)
    );

    // Result registers: cleared on launch, loaded in the final state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            geom_valid <= 1'b0; err_unknown <= 1'b0; err_unsupported <= 1'b0;
            id_mfr <= '0; id_dev <= '0;
            page_bytes <= '0; erase_kib <= '0; wide16 <= 1'b0;
            addr_cycles <= '0; block_count <= '0;
        end else begin
            done <= fin;
            if (launch) begin
                geom_valid <= 1'b0; err_unknown <= 1'b0; err_unsupported <= 1'b0;
                id_mfr <= '0; id_dev <= '0;
                page_bytes <= '0; erase_kib <= '0; wide16 <= 1'b0;
                addr_cycles <= '0; block_count <= '0;
            end else if (fin) begin
                id_mfr <= mfr_q;
                id_dev <= dev_q;
                if (!hit) begin
                    err_unknown <= 1'b1;
                end else if (page_reject) begin
                    err_unsupported <= 1'b1;
                end else begin
                    geom_valid  <= 1'b1;
                    page_bytes  <= g_page;
                    erase_kib   <= g_erase;
                    wide16      <= ent.wide;
                    addr_cycles <= g_cyc;
                    block_count <= g_blk;
                end
            end
        end
    end
endmodule

// File: rtl/nidp_checker.sv
// Protocol and result checks on the probe's ports, bound to the top.
module nidp_checker
    import nidp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rb_ready,
    input logic               bus_req,
    input logic               bus_ack,
    input logic [KIND_W-1:0]  bus_kind,
    input logic [BYTE_W-1:0]  bus_wdata,
    input logic               busy,
    input logic               done,
    input logic               geom_valid,
    input logic               err_unknown,
    input logic               err_unsupported,
    input logic [PAGE_W-1:0]  page_bytes,
    input logic [CYC_W-1:0]   addr_cycles
);
    // R1: an address operation always carries 0x00.
    assert_addr_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_kind == KIND_ADDR) |-> (bus_wdata == ID_ADDR));

    // R1: a pending request holds until acknowledged.
    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_kind) && $stable(bus_wdata)));

    // R2: read-ID is requested only while the device reports ready.
    assert_rid_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_kind == KIND_CMD && bus_wdata == OP_READ_ID) |-> rb_ready);

    // R10: at most one of valid / unknown / unsupported.
    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({geom_valid, err_unknown, err_unsupported}));

    // R6: a valid page size is a power of two of at least 512.
    assert_page_pow2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        geom_valid |-> ($countones(page_bytes) == 1 && page_bytes >= PAGE_W'(512)));

    // R8: a valid cycle count lies in 3..6.
    assert_cycles_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        geom_valid |-> (addr_cycles >= CYC_W'(3) && addr_cycles <= CYC_W'(6)));

    // R12: done lasts a single cycle.
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: no bus traffic outside a probe.
    assert_req_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);
endmodule

bind nand_id_probe nidp_checker i_chk (
    .clk(clk), .rst_n(rst_n), .rb_ready(rb_ready), .bus_req(bus_req),
    .bus_ack(bus_ack), .bus_kind(bus_kind), .bus_wdata(bus_wdata), .busy(busy),
    .done(done), .geom_valid(geom_valid), .err_unknown(err_unknown),
    .err_unsupported(err_unsupported), .page_bytes(page_bytes),
    .addr_cycles(addr_cycles)
);

// File: tb/test_nand_id_probe.sv
`timescale 1ns/1ps
module test_nand_id_probe;
    import nidp_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rb_ready = 1'b1, bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic bus_req, busy, done, geom_valid, err_unknown, err_unsupported, wide16;
    logic [1:0] bus_kind;
    logic [7:0] bus_wdata, id_mfr, id_dev;
    logic [13:0] page_bytes;
    logic [10:0] erase_kib;
    logic [2:0] addr_cycles;
    logic [21:0] block_count;

    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    nand_id_probe i_nand_id_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .rb_ready(rb_ready),
        .bus_req(bus_req), .bus_kind(bus_kind), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .done(done),
        .geom_valid(geom_valid), .err_unknown(err_unknown),
        .err_unsupported(err_unsupported), .id_mfr(id_mfr), .id_dev(id_dev),
        .page_bytes(page_bytes), .erase_kib(erase_kib), .wide16(wide16),
        .addr_cycles(addr_cycles), .block_count(block_count)
    );

    // Reference device table (sizes in plain units, 0 = open).
    int t_mfr[13]   = '{'hEC, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    int t_dev[13]   = '{'hD5, 'h6E, 'h73, 'h53, 'h75, 'h76, 'h79, 'hF1, 'hC1, 'hDA, 'hD3, 'hD5, 'h48};
    int t_page[13]  = '{8192, 256, 512, 512, 512, 512, 512, 0, 0, 0, 0, 0, 0};
    int t_chip[13]  = '{2048, 1, 16, 16, 32, 64, 128, 128, 128, 256, 1024, 2048, 2048};
    int t_erase[13] = '{1024, 4, 16, 16, 16, 16, 16, 0, 0, 0, 0, 0, 0};
    int t_wide[13]  = '{0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0};

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Bus responder and flash model; returns in the cycle busy has fallen.
    task automatic serve(input logic [7:0] m, input logic [7:0] d, input logic [7:0] x3,
                         input logic [7:0] x4, input logic [7:0] x5, input bit poke,
                         output int nreads, output int nff, output bit order_ok);
        int step = 0;
        int guard = 0;
        int rbc = 0;
        logic [7:0] b;
        nreads = 0; nff = 0; order_ok = 1'b1;
        while (busy && guard < 5000) begin
            guard++;
            if (!rb_ready) begin
                if (rbc == 0) rb_ready = 1'b1;
                else rbc--;
            end
            if (bus_req) begin
                if (!rb_ready) order_ok = 1'b0;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                case (bus_kind)
                    KIND_CMD: begin
                        if (bus_wdata == OP_RESET) begin
                            nff++;
                            if (step != 0) order_ok = 1'b0;
                            step = 1;
                            rb_ready = 1'b0;
                            rbc = $urandom_range(1, 6);
                        end else begin
                            if (bus_wdata != OP_READ_ID || step != 1 || !rb_ready) order_ok = 1'b0;
                            step = 2;
                        end
                    end
                    KIND_ADDR: begin
                        if (bus_wdata != 8'h00 || step != 2) order_ok = 1'b0;
                        step = 3;
                    end
                    default: begin
                        if (step != 3) order_ok = 1'b0;
                        case (nreads)
                            0: b = m;
                            1: b = d;
                            2: b = x3;
                            3: b = x4;
                            4: b = x5;
                            default: b = 8'hFF;
                        endcase
                        bus_rdata = {8'($urandom), b};   // R3: junk upper byte
                        if (poke && nreads == 0) start = 1'b1;
                        nreads++;
                    end
                endcase
                bus_ack = 1'b1;
                @(negedge clk);
                bus_ack = 1'b0;
                if (poke) start = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        if (guard >= 5000) check("R1 probe did not finish", 0, 1);
    endtask

    // Compare the published results against values computed from the requirements.
    task automatic verify(input logic [7:0] m, input logic [7:0] d, input logic [7:0] x4,
                          input int nreads, input int nff, input bit order_ok);
        int idx = -1;
        int pg, er, cyc, blk;
        for (int i = 12; i >= 0; i--)
            if (t_dev[i] == int'(d) && (t_mfr[i] == 0 || t_mfr[i] == int'(m))) idx = i;
        check("R1 op order", order_ok, 1);
        check("R12 single launch", nff, 1);
        check("R12 done with results", done, 1);
        check("R12 busy low at done", busy, 0);
        check("R3 id_mfr", id_mfr, m);
        check("R3 id_dev", id_dev, d);
        if (idx < 0) begin
            check("R10 err_unknown", err_unknown, 1);
            check("R10 valid low", geom_valid, 0);
            check("R10 page zero", page_bytes, 0);
            check("R5 reads unknown", nreads, 2);
        end else if (t_page[idx] == 256) begin
            check("R11 err_unsupported", err_unsupported, 1);
            check("R11 valid low", geom_valid, 0);
            check("R11 no extra reads", nreads, 2);
        end else begin
            pg = (t_page[idx] != 0) ? t_page[idx] : (1024 << (x4 & 3));
            er = (t_erase[idx] != 0) ? t_erase[idx] : (64 << ((x4 >> 4) & 3));
            if (pg <= 512) cyc = (t_chip[idx] <= 32) ? 3 : (t_chip[idx] <= 8192) ? 4 : 5;
            else cyc = (t_chip[idx] <= 128) ? 4 : (t_chip[idx] <= 32768) ? 5 : 6;
            blk = t_chip[idx] * 1024 / er;
            check("R4 geom_valid", geom_valid, 1);
            check("R4 no error", err_unknown | err_unsupported, 0);
            check("R5 read count", nreads, (t_page[idx] == 0 || t_erase[idx] == 0) ? 5 : 2);
            check("R6 page_bytes", page_bytes, pg);
            check("R7 erase_kib", erase_kib, er);
            check("R8 addr_cycles", addr_cycles, cyc);
            check("R9 block_count", block_count, blk);
            check("R13 wide16", wide16, t_wide[idx]);
        end
    endtask

    task automatic probe(input logic [7:0] m, input logic [7:0] d, input logic [7:0] x3,
                         input logic [7:0] x4, input logic [7:0] x5, input bit poke);
        int nr, nf;
        bit ok;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        serve(m, d, x3, x4, x5, poke, nr, nf, ok);
        verify(m, d, x4, nr, nf, ok);
        @(negedge clk);
        check("R12 done one cycle", done, 0);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int nr, nf;
        bit ok;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R14: reset state
        check("R14 busy", busy, 0);
        check("R14 done", done, 0);
        check("R14 bus_req", bus_req, 0);
        check("R14 flags", {geom_valid, err_unknown, err_unsupported}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R14 idle after release", busy, 0);

        // Directed corners
        probe(8'hEC, 8'hD5, 8'h11, 8'h22, 8'h33, 1'b0);  // R4 vendor row wins
        probe(8'h98, 8'hD5, 8'h01, 8'h15, 8'h40, 1'b0);  // R4 wildcard, R5/R6/R7 extended
        probe(8'h20, 8'h6E, 8'h00, 8'h00, 8'h00, 1'b0);  // R11 256-byte page
        probe(8'h2C, 8'h11, 8'h00, 8'h00, 8'h00, 1'b0);  // R10 unknown code
        probe(8'h20, 8'h73, 8'h00, 8'h00, 8'h00, 1'b0);  // R8 3 cycles small
        probe(8'h20, 8'h76, 8'h00, 8'h00, 8'h00, 1'b0);  // R8 4 cycles small
        probe(8'hAD, 8'hF1, 8'hFF, 8'h30, 8'hFF, 1'b0);  // R8 large, 128 MiB, R7 max erase
        probe(8'hAD, 8'hC1, 8'h00, 8'h03, 8'h00, 1'b0);  // R13 wide, R6 8K page
        probe(8'h20, 8'h53, 8'h00, 8'h00, 8'h00, 1'b0);  // R13 wide small page
        probe(8'hEC, 8'hDA, 8'h00, 8'h21, 8'h00, 1'b1);  // R12 start while busy ignored

        // R12: start held across completion relaunches on the next cycle
        @(negedge clk); start = 1'b1;
        @(negedge clk);
        serve(8'h20, 8'h79, 8'h00, 8'h00, 8'h00, 1'b0, nr, nf, ok);
        verify(8'h20, 8'h79, 8'h00, nr, nf, ok);
        @(negedge clk);
        check("R12 relaunch busy", busy, 1);
        check("R12 results cleared", geom_valid, 0);
        check("R12 relaunch reset cmd", {bus_req, bus_wdata}, {1'b1, OP_RESET});
        start = 1'b0;
        serve(8'h2C, 8'hD3, 8'h00, 8'h12, 8'h00, 1'b0, nr, nf, ok);
        verify(8'h2C, 8'hD3, 8'h12, nr, nf, ok);

        // Constrained random probes
        for (int k = 0; k < 60; k++) begin
            int sel = $urandom_range(0, 15);
            logic [7:0] m = 8'($urandom);
            logic [7:0] d = 8'($urandom);
            if (sel < 13) begin
                d = 8'(t_dev[sel]);
                if (t_mfr[sel] != 0 && $urandom_range(0, 1) == 1) m = 8'(t_mfr[sel]);
            end
            probe(m, d, 8'($urandom), 8'($urandom), 8'($urandom), 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule